// File: doc/BRIEF.md
# Core idle-state controller

This block governs the idle behaviour of one processor core shared by several hardware threads (two by default). Each thread may ask for an idle depth while it is running: light halt (C1), enhanced halt (C1E), clock-stopped with caches flushed (C3) or powered-down with state saved (C6). The controller combines the per-thread depths into a single core state. The core goes idle only when every thread is idle, and then only to the shallowest depth any thread asked for.

Entry into the deeper states is a series of request/acknowledge handshakes with external agents: flushing the private caches, stopping the core clocks, saving architectural state and removing the supply. The exit runs the matching steps in reverse. An interrupt or a monitored-address hit wakes only the thread it targets, and that alone is enough to bring the whole core back to active. A wake that lands while an entry handshake is still open is remembered. The open step is allowed to finish and the controller then unwinds only the steps already taken. Snoops are answered in the light states. In the clock-stopped and powered-down states they are dropped and never wake the core.

Top module: `core_idle_ctl`

## Requirements
- R1: Levels are 3-bit codes: active=0, C1=1, C1E=2, C3=3, C6=4, and request codes above 4 are taken as 4. The core state is the numeric minimum of the thread levels, so C1E on one thread and C3 on the other gives `coreState`=2.
- R2: A monitored-address hit (`monHit[t]`) returns thread t to active only if its current idle request was made with `idleViaWait[t]`=1. Otherwise the hit leaves the thread and the core state unchanged.
- R3: An interrupt (`irq[t]`) returns only thread t to active (`threadAwake[t]`=1, other bits unchanged), and the core then reports `coreState`=0.
- R4: The core leaves active only when every thread holds a nonzero level. With any thread active, `coreState` stays 0 and no handshake output rises.
- R5: In C1 or C1E a `snoopValid` cycle gives `snoopAck`=1 in the following cycle, and `coreState` is unchanged.
- R6: C3 entry raises `flushReq` first and raises `clkStop` only after `flushDone`. `coreState` reads 3 only once `clkStopped` is seen. The exit lowers `clkStop` and waits for `clkStopped` to drop.
- R7: In C3 and C6 a snoop produces no `snoopAck` and does not change `coreState`.
- R8: C6 entry runs flush, then `saveReq` until `saveDone`, then `clkStop`, then `pwrOff` until `pwrGood` drops, and `coreState` then reads 4. The exit lowers `pwrOff` and waits for `pwrGood`, then releases the clock, then raises `restoreReq` until `restoreDone`.
- R9: A wake during entry never cuts an open handshake short. The pending step completes and only the steps already taken are undone. No later entry step is started, and `restoreReq` is raised only if power was actually removed. The wake is kept even if the thread asks to go idle again before the step completes.
- R10: Reset (`rstN`=0) returns the core to `coreState`=0 with every thread active and every handshake output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| idleReq | input | NUM_THREADS | Per-thread idle request strobe |
| idleLevel | input | 3*NUM_THREADS | Requested level per thread, thread t at bits [3t+2:3t] |
| idleViaWait | input | NUM_THREADS | Request was made through the monitor/wait path |
| irq | input | NUM_THREADS | Interrupt aimed at thread t |
| monHit | input | NUM_THREADS | Monitored address of thread t was written |
| snoopValid | input | 1 | Incoming snoop |
| flushDone | input | 1 | Cache flush complete |
| clkStopped | input | 1 | Core clocks are stopped (level) |
| saveDone | input | 1 | State save complete |
| pwrGood | input | 1 | Core supply is up (level) |
| restoreDone | input | 1 | State restore complete |
| coreState | output | 3 | Resident core level (0 while active or in transit) |
| threadAwake | output | NUM_THREADS | Thread t is active |
| snoopAck | output | 1 | Snoop serviced |
| flushReq | output | 1 | Flush private caches to the shared cache |
| clkStop | output | 1 | Stop the core clocks |
| saveReq | output | 1 | Save architectural state |
| pwrOff | output | 1 | Remove the core supply |
| restoreReq | output | 1 | Restore architectural state |

## Verification
The bench builds the block with the default of two threads. That is the smallest count at which one thread can be woken while its sibling stays idle, so the shallowest-state resolution, the single-thread wake and the rule that every thread must be idle can all be exercised. The bench acts as every external agent and answers each handshake by hand. This lets it land an interrupt inside the flush wait and inside the clock-stop wait of a C6 entry, and so check both unwinding paths of the wake latch.

// File: rtl/cidle_pkg.sv
package cidle_pkg;

  typedef logic [2:0] lvl_t;

  localparam lvl_t LV_C0  = 3'd0;
  localparam lvl_t LV_C1  = 3'd1;
  localparam lvl_t LV_C1E = 3'd2;
  localparam lvl_t LV_C3  = 3'd3;
  localparam lvl_t LV_C6  = 3'd4;

  // Strobes from the sequencer to the datapath.
  typedef struct packed {
    logic setFlush;
    logic clrFlush;
    logic setSave;
    logic clrSave;
    logic setStop;
    logic clrStop;
    logic setOff;
    logic clrOff;
    logic setRest;
    logic clrRest;
    logic loadLvl;
    logic clrLvl;
    logic clrPend;
    logic inEntry;
    logic snoopOk;
  } strobe_t;

  typedef enum logic [3:0] {
    S_ACT, S_LIGHT, S_FLUSH, S_SAVE, S_STOP, S_OFF,
    S_C3, S_C6, S_PWRUP, S_CLKRUN, S_RESTORE
  } seq_e;

endpackage

// File: rtl/cidle_thread_slot.sv
module cidle_thread_slot
  import cidle_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic reqValid,
  input  lvl_t reqLevel,
  input  logic reqViaWait,
  input  logic irq,
  input  logic monHit,
  output lvl_t level,
  output logic awake
);

  lvl_t levelQ;
  logic viaWaitQ;
  logic wakeNow;
  lvl_t reqClamped;

  assign wakeNow    = irq | (monHit & viaWaitQ);
  assign reqClamped = (reqLevel > LV_C6) ? LV_C6 : reqLevel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      levelQ   <= LV_C0;
      viaWaitQ <= 1'b0;
    end else if (wakeNow) begin
      levelQ   <= LV_C0;
      viaWaitQ <= 1'b0;
    end else if (reqValid && levelQ == LV_C0 && reqClamped != LV_C0) begin
      levelQ   <= reqClamped;
      viaWaitQ <= reqViaWait;
    end
  end

  assign level = levelQ;
  assign awake = (levelQ == LV_C0);

  // R2
  no_stray_monitor_wake_chk: assert property (@(posedge clk) disable iff (!rstN)
    (levelQ != LV_C0 && !viaWaitQ && !irq) |=> (levelQ == $past(levelQ)));

  // R3
  irq_wakes_thread_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |=> (levelQ == LV_C0));

endmodule

// File: rtl/cidle_datapath.sv
module cidle_datapath
  import cidle_pkg::*;
#(
  parameter int NUM_THREADS = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_THREADS-1:0]   idleReq,
  input  logic [3*NUM_THREADS-1:0] idleLevel,
  input  logic [NUM_THREADS-1:0]   idleViaWait,
  input  logic [NUM_THREADS-1:0]   irq,
  input  logic [NUM_THREADS-1:0]   monHit,
  input  logic                     snoopValid,
  input  strobe_t                  stb,
  output lvl_t                     target,
  output logic                     wakeSeen,
  output lvl_t                     coreState,
  output logic [NUM_THREADS-1:0]   threadAwake,
  output logic                     snoopAck,
  output logic                     flushReq,
  output logic                     clkStop,
  output logic                     saveReq,
  output logic                     pwrOff,
  output logic                     restoreReq
);

  lvl_t levels [NUM_THREADS];

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thread
    cidle_thread_slot u_slot (
      .clk       (clk),
      .rstN      (rstN),
      .reqValid  (idleReq[t]),
      .reqLevel  (idleLevel[3*t +: 3]),
      .reqViaWait(idleViaWait[t]),
      .irq       (irq[t]),
      .monHit    (monHit[t]),
      .level     (levels[t]),
      .awake     (threadAwake[t])
    );
  end

  // Shallowest requested level wins.
  always_comb begin
    target = LV_C6;
    for (int t = 0; t < NUM_THREADS; t++) begin
      if (levels[t] < target) target = levels[t];
    end
  end

  logic pendQ, flushQ, saveQ, stopQ, offQ, restQ, snoopAckQ;
  lvl_t coreLvlQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendQ     <= 1'b0;
      flushQ    <= 1'b0;
      saveQ     <= 1'b0;
      stopQ     <= 1'b0;
      offQ      <= 1'b0;
      restQ     <= 1'b0;
      snoopAckQ <= 1'b0;
      coreLvlQ  <= LV_C0;
    end else begin
      if (stb.clrPend)                          pendQ <= 1'b0;
      else if (stb.inEntry && target == LV_C0)  pendQ <= 1'b1;

      if (stb.setFlush)      flushQ <= 1'b1;
      else if (stb.clrFlush) flushQ <= 1'b0;
      if (stb.setSave)       saveQ  <= 1'b1;
      else if (stb.clrSave)  saveQ  <= 1'b0;
      if (stb.setStop)       stopQ  <= 1'b1;
      else if (stb.clrStop)  stopQ  <= 1'b0;
      if (stb.setOff)        offQ   <= 1'b1;
      else if (stb.clrOff)   offQ   <= 1'b0;
      if (stb.setRest)       restQ  <= 1'b1;
      else if (stb.clrRest)  restQ  <= 1'b0;

      if (stb.loadLvl)       coreLvlQ <= target;
      else if (stb.clrLvl)   coreLvlQ <= LV_C0;

      snoopAckQ <= snoopValid & stb.snoopOk;
    end
  end

  assign wakeSeen   = pendQ | (target == LV_C0);
  assign coreState  = coreLvlQ;
  assign snoopAck   = snoopAckQ;
  assign flushReq   = flushQ;
  assign saveReq    = saveQ;
  assign clkStop    = stopQ;
  assign pwrOff     = offQ;
  assign restoreReq = restQ;

  // R1
  resident_matches_min_chk: assert property (@(posedge clk) disable iff (!rstN)
    (coreLvlQ != LV_C0) |-> (target == coreLvlQ || target == LV_C0));

  // R4
  entry_needs_all_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flushQ) |-> ($past(target) != LV_C0));

  // R6
  clock_after_flush_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stopQ) |-> (!flushQ && !saveQ));

  // R7
  no_snoop_when_deep_chk: assert property (@(posedge clk) disable iff (!rstN)
    snoopAckQ |-> (coreLvlQ < LV_C3));

  // R8
  power_after_clock_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(offQ) |-> (stopQ && !saveQ));

  // R8
  restore_after_power_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(restQ) |-> (!offQ && !stopQ));

endmodule

// File: rtl/cidle_seq_ctrl.sv
module cidle_seq_ctrl
  import cidle_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  lvl_t    target,
  input  logic    wakeSeen,
  input  logic    flushDone,
  input  logic    saveDone,
  input  logic    clkStopped,
  input  logic    pwrGood,
  input  logic    restoreDone,
  output strobe_t stb
);

  seq_e st, nxt;
  logic goalC6Q, needRestQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st        <= S_ACT;
      goalC6Q   <= 1'b0;
      needRestQ <= 1'b0;
    end else begin
      st <= nxt;
      if (st == S_ACT && target >= LV_C3) goalC6Q <= (target == LV_C6);
      if (st == S_ACT)                    needRestQ <= 1'b0;
      else if (st == S_OFF && !pwrGood)   needRestQ <= 1'b1;
    end
  end

  always_comb begin
    nxt = st;
    stb = '0;
    stb.inEntry = (st == S_FLUSH) || (st == S_SAVE) || (st == S_STOP) || (st == S_OFF);
    stb.snoopOk = (st == S_ACT) || (st == S_LIGHT);
    case (st)
      S_ACT: begin
        stb.clrPend = 1'b1;
        if (target != LV_C0) begin
          if (target <= LV_C1E) begin
            nxt = S_LIGHT;
            stb.loadLvl = 1'b1;
          end else begin
            nxt = S_FLUSH;
            stb.setFlush = 1'b1;
          end
        end
      end
      S_LIGHT: begin
        if (target == LV_C0) begin
          nxt = S_ACT;
          stb.clrLvl = 1'b1;
        end
      end
      S_FLUSH: begin
        if (flushDone) begin
          stb.clrFlush = 1'b1;
          if (wakeSeen) begin
            nxt = S_ACT;
          end else if (goalC6Q) begin
            nxt = S_SAVE;
            stb.setSave = 1'b1;
          end else begin
            nxt = S_STOP;
            stb.setStop = 1'b1;
          end
        end
      end
      S_SAVE: begin
        if (saveDone) begin
          stb.clrSave = 1'b1;
          if (wakeSeen) begin
            nxt = S_ACT;
          end else begin
            nxt = S_STOP;
            stb.setStop = 1'b1;
          end
        end
      end
      S_STOP: begin
        if (clkStopped) begin
          if (wakeSeen) begin
            nxt = S_CLKRUN;
            stb.clrStop = 1'b1;
          end else if (goalC6Q) begin
            nxt = S_OFF;
            stb.setOff = 1'b1;
          end else begin
            nxt = S_C3;
            stb.loadLvl = 1'b1;
          end
        end
      end
      S_OFF: begin
        if (!pwrGood) begin
          if (wakeSeen) begin
            nxt = S_PWRUP;
            stb.clrOff = 1'b1;
          end else begin
            nxt = S_C6;
            stb.loadLvl = 1'b1;
          end
        end
      end
      S_C3: begin
        if (target == LV_C0) begin
          nxt = S_CLKRUN;
          stb.clrStop = 1'b1;
          stb.clrLvl  = 1'b1;
        end
      end
      S_C6: begin
        if (target == LV_C0) begin
          nxt = S_PWRUP;
          stb.clrOff = 1'b1;
          stb.clrLvl = 1'b1;
        end
      end
      S_PWRUP: begin
        if (pwrGood) begin
          nxt = S_CLKRUN;
          stb.clrStop = 1'b1;
        end
      end
      S_CLKRUN: begin
        if (!clkStopped) begin
          if (needRestQ) begin
            nxt = S_RESTORE;
            stb.setRest = 1'b1;
          end else begin
            nxt = S_ACT;
          end
        end
      end
      S_RESTORE: begin
        if (restoreDone) begin
          nxt = S_ACT;
          stb.clrRest = 1'b1;
        end
      end
      default: nxt = S_ACT;
    endcase
  end

  // R9
  flush_not_aborted_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st == S_FLUSH && !flushDone) |=> (st == S_FLUSH));

  // R9
  save_not_aborted_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st == S_SAVE && !saveDone) |=> (st == S_SAVE));

endmodule

// File: rtl/core_idle_ctl.sv
module core_idle_ctl
  import cidle_pkg::*;
#(
  parameter int NUM_THREADS = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_THREADS-1:0]   idleReq,
  input  logic [3*NUM_THREADS-1:0] idleLevel,
  input  logic [NUM_THREADS-1:0]   idleViaWait,
  input  logic [NUM_THREADS-1:0]   irq,
  input  logic [NUM_THREADS-1:0]   monHit,
  input  logic                     snoopValid,
  input  logic                     flushDone,
  input  logic                     clkStopped,
  input  logic                     saveDone,
  input  logic                     pwrGood,
  input  logic                     restoreDone,
  output logic [2:0]               coreState,
  output logic [NUM_THREADS-1:0]   threadAwake,
  output logic                     snoopAck,
  output logic                     flushReq,
  output logic                     clkStop,
  output logic                     saveReq,
  output logic                     pwrOff,
  output logic                     restoreReq
);

  strobe_t stb;
  lvl_t    target;
  logic    wakeSeen;

  cidle_datapath #(.NUM_THREADS(NUM_THREADS)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .idleReq    (idleReq),
    .idleLevel  (idleLevel),
    .idleViaWait(idleViaWait),
    .irq        (irq),
    .monHit     (monHit),
    .snoopValid (snoopValid),
    .stb        (stb),
    .target     (target),
    .wakeSeen   (wakeSeen),
    .coreState  (coreState),
    .threadAwake(threadAwake),
    .snoopAck   (snoopAck),
    .flushReq   (flushReq),
    .clkStop    (clkStop),
    .saveReq    (saveReq),
    .pwrOff     (pwrOff),
    .restoreReq (restoreReq)
  );

  cidle_seq_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .target     (target),
    .wakeSeen   (wakeSeen),
    .flushDone  (flushDone),
    .saveDone   (saveDone),
    .clkStopped (clkStopped),
    .pwrGood    (pwrGood),
    .restoreDone(restoreDone),
    .stb        (stb)
  );

endmodule

// File: tb/sim_core_idle_ctl.sv
`timescale 1ns/1ps
module sim_core_idle_ctl;

  logic       clk = 1'b0;
  logic       rstN;
  logic [1:0] idleReq, idleViaWait, irq, monHit;
  logic [5:0] idleLevel;
  logic       snoopValid, flushDone, clkStopped, saveDone, pwrGood, restoreDone;
  logic [2:0] coreState;
  logic [1:0] threadAwake;
  logic       snoopAck, flushReq, clkStop, saveReq, pwrOff, restoreReq;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  core_idle_ctl #(.NUM_THREADS(2)) u0 (
    .clk(clk), .rstN(rstN), .idleReq(idleReq), .idleLevel(idleLevel),
    .idleViaWait(idleViaWait), .irq(irq), .monHit(monHit),
    .snoopValid(snoopValid), .flushDone(flushDone), .clkStopped(clkStopped),
    .saveDone(saveDone), .pwrGood(pwrGood), .restoreDone(restoreDone),
    .coreState(coreState), .threadAwake(threadAwake), .snoopAck(snoopAck),
    .flushReq(flushReq), .clkStop(clkStop), .saveReq(saveReq),
    .pwrOff(pwrOff), .restoreReq(restoreReq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reqOne(input int t, input logic [2:0] lvl, input logic viaWait);
    idleReq[t] = 1'b1;
    idleLevel[3*t +: 3] = lvl;
    idleViaWait[t] = viaWait;
    tick(1);
    idleReq[t] = 1'b0;
    idleViaWait[t] = 1'b0;
  endtask

  task automatic reqBoth(input logic [2:0] l0, input logic [2:0] l1);
    idleReq = 2'b11;
    idleLevel = {l1, l0};
    tick(1);
    idleReq = 2'b00;
  endtask

  task automatic pulseIrq(input int t);
    irq[t] = 1'b1;
    tick(1);
    irq[t] = 1'b0;
  endtask

  task automatic waitFlush(input logic v);
    for (int i = 0; i < 40 && flushReq !== v; i++) tick(1);
  endtask

  task automatic testReset;
    chk("R10 reset coreState", coreState, 0);
    chk("R10 reset awake", threadAwake, 2'b11);
    chk("R10 reset handshakes", {flushReq, clkStop, saveReq, pwrOff, restoreReq, snoopAck}, 0);
  endtask

  task automatic testResolveAndSnoop;
    reqBoth(3'd2, 3'd3);
    tick(2);
    chk("R1 min of C1E and C3", coreState, 2);
    chk("R1 no flush for C1E", flushReq, 0);
    snoopValid = 1'b1;
    tick(1);
    snoopValid = 1'b0;
    chk("R5 snoop acked in C1E", snoopAck, 1);
    chk("R5 stays in C1E", coreState, 2);
    pulseIrq(0);
    chk("R3 only thread 0 woken", threadAwake, 2'b01);
    tick(1);
    chk("R3 core active after one wake", coreState, 0);
    pulseIrq(1);
    tick(1);
  endtask

  task automatic testAllIdleRule;
    reqOne(0, 3'd3, 1'b0);
    tick(4);
    chk("R4 one thread idle only", coreState, 0);
    chk("R4 no handshake", {flushReq, clkStop}, 0);
    chk("R4 thread states", threadAwake, 2'b10);
    pulseIrq(0);
    tick(1);
  endtask

  task automatic testMonitor;
    reqOne(0, 3'd1, 1'b1);
    reqOne(1, 3'd7, 1'b0);
    tick(2);
    chk("R1 clamp 7 to C6, min is C1", coreState, 1);
    monHit[1] = 1'b1;
    tick(1);
    monHit[1] = 1'b0;
    tick(1);
    chk("R2 hit ignored without wait path", threadAwake, 2'b00);
    chk("R2 core stays C1", coreState, 1);
    monHit[0] = 1'b1;
    tick(1);
    monHit[0] = 1'b0;
    chk("R2 hit wakes wait-path thread", threadAwake, 2'b01);
    tick(1);
    chk("R2 core active", coreState, 0);
    pulseIrq(1);
    tick(1);
  endtask

  task automatic testC3;
    reqBoth(3'd3, 3'd4);
    waitFlush(1'b1);
    chk("R6 flush first", {flushReq, clkStop}, 2'b10);
    tick(2);
    chk("R6 clock held during flush", clkStop, 0);
    flushDone = 1'b1;
    tick(1);
    flushDone = 1'b0;
    chk("R6 clock stop after flush", {flushReq, clkStop}, 2'b01);
    chk("R6 not resident before ack", coreState, 0);
    clkStopped = 1'b1;
    tick(1);
    chk("R6 resident in C3", coreState, 3);
    snoopValid = 1'b1;
    tick(1);
    snoopValid = 1'b0;
    tick(1);
    chk("R7 snoop dropped in C3", snoopAck, 0);
    chk("R7 C3 kept after snoop", coreState, 3);
    pulseIrq(1);
    tick(1);
    chk("R6 exit releases clock", clkStop, 0);
    clkStopped = 1'b0;
    tick(2);
    chk("R6 back to active", coreState, 0);
    pulseIrq(0);
    tick(1);
  endtask

  task automatic testC6;
    reqBoth(3'd4, 3'd4);
    waitFlush(1'b1);
    flushDone = 1'b1;
    tick(1);
    flushDone = 1'b0;
    chk("R8 save after flush", {saveReq, clkStop}, 2'b10);
    saveDone = 1'b1;
    tick(1);
    saveDone = 1'b0;
    chk("R8 clock stop after save", {saveReq, clkStop, pwrOff}, 3'b010);
    clkStopped = 1'b1;
    tick(1);
    chk("R8 power off after clock", pwrOff, 1);
    pwrGood = 1'b0;
    tick(1);
    chk("R8 resident in C6", coreState, 4);
    snoopValid = 1'b1;
    tick(1);
    snoopValid = 1'b0;
    tick(1);
    chk("R7 snoop dropped in C6", {snoopAck, coreState}, 4'b0100);
    pulseIrq(0);
    for (int i = 0; i < 10 && pwrOff; i++) tick(1);
    chk("R8 power first on exit", {pwrOff, clkStop, restoreReq}, 3'b010);
    pwrGood = 1'b1;
    for (int i = 0; i < 10 && clkStop; i++) tick(1);
    chk("R8 no restore before clock runs", restoreReq, 0);
    clkStopped = 1'b0;
    for (int i = 0; i < 10 && !restoreReq; i++) tick(1);
    chk("R8 restore raised last", {restoreReq, pwrOff, clkStop}, 3'b100);
    restoreDone = 1'b1;
    tick(1);
    restoreDone = 1'b0;
    chk("R8 active after restore", {coreState, restoreReq}, 0);
    pulseIrq(1);
    tick(1);
  endtask

  task automatic testMidEntryWake;
    reqBoth(3'd4, 3'd4);
    waitFlush(1'b1);
    pulseIrq(0);
    reqOne(0, 3'd4, 1'b0);
    tick(2);
    chk("R9 flush still open after wake", {flushReq, saveReq}, 2'b10);
    flushDone = 1'b1;
    tick(1);
    flushDone = 1'b0;
    chk("R9 latched wake skips save", {flushReq, saveReq}, 2'b00);
    chk("R9 core active", coreState, 0);
    waitFlush(1'b1);
    flushDone = 1'b1;
    tick(1);
    flushDone = 1'b0;
    saveDone = 1'b1;
    tick(1);
    saveDone = 1'b0;
    pulseIrq(1);
    clkStopped = 1'b1;
    tick(1);
    chk("R9 wake in clock wait: no power off", {pwrOff, clkStop}, 2'b00);
    clkStopped = 1'b0;
    tick(3);
    chk("R9 no restore without power loss", {restoreReq, coreState}, 0);
    pulseIrq(0);
    tick(1);
  endtask

  task automatic testResetMidIdle;
    reqBoth(3'd1, 3'd1);
    tick(2);
    chk("R1 both C1", coreState, 1);
    rstN = 1'b0;
    tick(1);
    rstN = 1'b1;
    tick(2);
    chk("R10 reset clears idle", coreState, 0);
    chk("R10 reset wakes threads", threadAwake, 2'b11);
  endtask

  initial begin
    rstN = 1'b0;
    idleReq = '0; idleViaWait = '0; irq = '0; monHit = '0; idleLevel = '0;
    snoopValid = 1'b0; flushDone = 1'b0; clkStopped = 1'b0; saveDone = 1'b0;
    pwrGood = 1'b1; restoreDone = 1'b0;
    tick(3);
    rstN = 1'b1;
    tick(1);
    testReset();
    testResolveAndSnoop();
    testAllIdleRule();
    testMonitor();
    testC3();
    testC6();
    testMidEntryWake();
    testResetMidIdle();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

endmodule